// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for two requesters at once: an instruction-fetch port and a data port. Each requester owns a small fully-associative first-level buffer that answers in the same cycle. Behind them sits one shared, larger, fully-associative second-level table. When a first-level search fails, the shared table is searched in the following cycle. A hit there answers the requester and copies the entry into that requester's first-level buffer. A miss there flags a page-miss fault on that requester.

Each entry holds a 2-bit page-size code, so pages of 1 KB, 4 KB, 64 KB and 1 MB can live side by side. Software fills the shared table through a write port that selects one slot per write. Every such write empties both first-level buffers, so no stale copy can outlive its source. A requester holds its request and address steady while its ready output is low.

Top module: `xlat_top`

## Requirements
- R1: After reset every entry in all three tables is invalid: with no request both ready outputs are low, and the first access stalls one cycle and then returns a fault.
- R2: The page-size code selects the offset width: 0 = 10 bits, 1 = 12 bits, 2 = 16 bits, 3 = 20 bits. Address bits at or above the offset width must equal the entry's virtual page bits. The physical address is the entry's page bits above the offset joined with the virtual address bits below it.
- R3: When a requester's own first-level buffer holds a matching entry, ready is high in the same cycle as the request, with the translated address and no fault.
- R4: On a first-level miss, ready is low for exactly one cycle, and in the next cycle the shared table's result is presented with ready high.
- R5: A shared-table miss raises the fault output together with ready. Nothing is copied into the first-level buffer, so repeating the access stalls again.
- R6: A shared-table hit copies the entry into the requester's first-level buffer, so the next access to that page completes with no stall.
- R7: Copies go into first-level slots chosen by a round-robin pointer that advances on every copy. With 4 instruction entries, the fifth distinct page replaces the first.
- R8: When both requesters miss in the same cycle, the data port is served in the next cycle and the instruction port one cycle later. The shared table performs at most one search per cycle.
- R9: A software write to the shared table invalidates every entry in both first-level buffers, so the next access to any page stalls. A copy due at the same clock edge as the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_req | input | 1 | Instruction-side request |
| i_va | input | 32 | Instruction-side virtual address |
| i_ready | output | 1 | Instruction-side result valid |
| i_pa | output | 32 | Instruction-side physical address |
| i_fault | output | 1 | Instruction-side page-miss fault |
| d_req | input | 1 | Data-side request |
| d_va | input | 32 | Data-side virtual address |
| d_ready | output | 1 | Data-side result valid |
| d_pa | output | 32 | Data-side physical address |
| d_fault | output | 1 | Data-side page-miss fault |
| sw_we | input | 1 | Shared-table write strobe |
| sw_idx | input | 5 | Shared-table slot to write |
| sw_valid | input | 1 | Valid bit of written entry |
| sw_psz | input | 2 | Page-size code of written entry |
| sw_vpn | input | 22 | Virtual page bits (address bits 31:10) |
| sw_ppn | input | 22 | Physical page bits (address bits 31:10) |

## Verification
A first-level hit shows on ready, address and fault in the same cycle, so the bench drives inputs at the falling edge and samples one nanosecond later, before the next rising edge. A first-level miss is due one rising edge later, and an instruction request that loses arbitration is due two edges later. The bench samples each of these a whole cycle apart. A reference model of all three tables, including the round-robin pointers and the invalidation on writes, predicts which case applies for each access. Software writes take effect at the edge after the strobe, so requests are dropped for that cycle before the next access.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int ADDR_W  = 32;
  parameter int MIN_OFS = 10;
  localparam int PN_W   = ADDR_W - MIN_OFS;

  typedef struct packed {
    logic [1:0]      psz;
    logic [PN_W-1:0] vpn;
    logic [PN_W-1:0] ppn;
  } xlat_ent_t;

  // page-number bits that take part in the compare for a size code
  function automatic logic [PN_W-1:0] pn_keep(input logic [1:0] psz);
    logic [PN_W-1:0] ones;
    ones = '1;
    case (psz)
      2'd0:    return ones;
      2'd1:    return ones << 2;
      2'd2:    return ones << 6;
      default: return ones << 10;
    endcase
  endfunction

  function automatic logic ent_match(input xlat_ent_t e, input logic [ADDR_W-1:0] va);
    return ((e.vpn ^ va[ADDR_W-1:MIN_OFS]) & pn_keep(e.psz)) == '0;
  endfunction

  function automatic logic [ADDR_W-1:0] ent_xlate(input xlat_ent_t e, input logic [ADDR_W-1:0] va);
    logic [PN_W-1:0] k;
    k = pn_keep(e.psz);
    return {(e.ppn & k) | (va[ADDR_W-1:MIN_OFS] & ~k), va[MIN_OFS-1:0]};
  endfunction
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] va,
  output logic              hit,
  output xlat_ent_t         hit_ent,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_valid,
  input  xlat_ent_t         wr_ent,
  input  logic              flush
);
  logic [DEPTH-1:0] vld_q, vld_d;
  xlat_ent_t        ent_q [DEPTH];

  // lowest matching slot wins
  always_comb begin
    hit     = 1'b0;
    hit_ent = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (vld_q[s] && ent_match(ent_q[s], va)) begin
        hit     = 1'b1;
        hit_ent = ent_q[s];
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (flush)
      vld_d = '0;
    else if (wr_en)
      vld_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && !flush && wr_idx == IW'(s))
          ent_q[s] <= wr_ent;
      end
    end
  endgenerate
endmodule

// File: rtl/xlat_sched.sv
module xlat_sched #(
  parameter int I_DEPTH = 4,
  parameter int D_DEPTH = 8,
  parameter int IIW     = (I_DEPTH > 1) ? $clog2(I_DEPTH) : 1,
  parameter int DIW     = (D_DEPTH > 1) ? $clog2(D_DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           d_req,
  input  logic           d_uhit,
  input  logic           i_req,
  input  logic           i_uhit,
  input  logic           sw_we,
  input  logic           main_hit,
  output logic           d_srv,
  output logic           i_srv,
  output logic           d_gnt,
  output logic           i_gnt,
  output logic           d_fill,
  output logic           i_fill,
  output logic [DIW-1:0] d_ptr,
  output logic [IIW-1:0] i_ptr
);
  logic           d_srv_d, i_srv_d;
  logic [DIW-1:0] d_ptr_d;
  logic [IIW-1:0] i_ptr_d;

  // data side has priority for the shared table
  always_comb begin
    d_gnt   = d_req && !d_uhit && !d_srv;
    i_gnt   = i_req && !i_uhit && !i_srv && !d_gnt;
    d_srv_d = d_gnt;
    i_srv_d = i_gnt;
    d_fill  = d_srv && d_req && main_hit && !sw_we;
    i_fill  = i_srv && i_req && main_hit && !sw_we;
    d_ptr_d = d_ptr;
    i_ptr_d = i_ptr;
    if (d_fill) d_ptr_d = (d_ptr == DIW'(D_DEPTH - 1)) ? '0 : d_ptr + 1'b1;
    if (i_fill) i_ptr_d = (i_ptr == IIW'(I_DEPTH - 1)) ? '0 : i_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_srv <= 1'b0;
      i_srv <= 1'b0;
      d_ptr <= '0;
      i_ptr <= '0;
    end else begin
      d_srv <= d_srv_d;
      i_srv <= i_srv_d;
      d_ptr <= d_ptr_d;
      i_ptr <= i_ptr_d;
    end
  end
endmodule

// File: rtl/xlat_top.sv
module xlat_top
  import xlat_pkg::*;
#(
  parameter int MAIN_DEPTH = 32,
  parameter int I_DEPTH    = 4,
  parameter int D_DEPTH    = 8,
  localparam int MW  = $clog2(MAIN_DEPTH),
  localparam int IIW = (I_DEPTH > 1) ? $clog2(I_DEPTH) : 1,
  localparam int DIW = (D_DEPTH > 1) ? $clog2(D_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_req,
  input  logic [ADDR_W-1:0] i_va,
  output logic              i_ready,
  output logic [ADDR_W-1:0] i_pa,
  output logic              i_fault,
  input  logic              d_req,
  input  logic [ADDR_W-1:0] d_va,
  output logic              d_ready,
  output logic [ADDR_W-1:0] d_pa,
  output logic              d_fault,
  input  logic              sw_we,
  input  logic [MW-1:0]     sw_idx,
  input  logic              sw_valid,
  input  logic [1:0]        sw_psz,
  input  logic [PN_W-1:0]   sw_vpn,
  input  logic [PN_W-1:0]   sw_ppn
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              d_uhit, i_uhit, main_hit;
  xlat_ent_t         d_uent, i_uent, main_ent, sw_ent;
  logic              d_srv, i_srv, d_gnt, i_gnt, d_fill, i_fill;
  logic [DIW-1:0]    d_ptr;
  logic [IIW-1:0]    i_ptr;
  logic [ADDR_W-1:0] main_va;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sw_ent  = '{psz: sw_psz, vpn: sw_vpn, ppn: sw_ppn};
  assign main_va = d_srv ? d_va : i_va;

  xlat_cam #(.DEPTH(D_DEPTH)) u_dbuf (
    .clk(clk), .rst_n(rst_int_n), .va(d_va), .hit(d_uhit), .hit_ent(d_uent),
    .wr_en(d_fill), .wr_idx(d_ptr), .wr_valid(1'b1), .wr_ent(main_ent), .flush(sw_we)
  );

  xlat_cam #(.DEPTH(I_DEPTH)) u_ibuf (
    .clk(clk), .rst_n(rst_int_n), .va(i_va), .hit(i_uhit), .hit_ent(i_uent),
    .wr_en(i_fill), .wr_idx(i_ptr), .wr_valid(1'b1), .wr_ent(main_ent), .flush(sw_we)
  );

  xlat_cam #(.DEPTH(MAIN_DEPTH)) u_main (
    .clk(clk), .rst_n(rst_int_n), .va(main_va), .hit(main_hit), .hit_ent(main_ent),
    .wr_en(sw_we), .wr_idx(sw_idx), .wr_valid(sw_valid), .wr_ent(sw_ent), .flush(1'b0)
  );

  xlat_sched #(.I_DEPTH(I_DEPTH), .D_DEPTH(D_DEPTH)) u_sched (
    .clk(clk), .rst_n(rst_int_n),
    .d_req(d_req), .d_uhit(d_uhit), .i_req(i_req), .i_uhit(i_uhit),
    .sw_we(sw_we), .main_hit(main_hit),
    .d_srv(d_srv), .i_srv(i_srv), .d_gnt(d_gnt), .i_gnt(i_gnt),
    .d_fill(d_fill), .i_fill(i_fill), .d_ptr(d_ptr), .i_ptr(i_ptr)
  );

  always_comb begin
    d_ready = d_req && (d_uhit || d_srv);
    d_fault = d_req && d_srv && !main_hit;
    d_pa    = d_srv ? ent_xlate(main_ent, d_va) : ent_xlate(d_uent, d_va);
    i_ready = i_req && (i_uhit || i_srv);
    i_fault = i_req && i_srv && !main_hit;
    i_pa    = i_srv ? ent_xlate(main_ent, i_va) : ent_xlate(i_uent, i_va);
  end
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker (
  input logic clk,
  input logic rst_n,
  input logic d_req,
  input logic d_ready,
  input logic d_fault,
  input logic d_uhit,
  input logic i_req,
  input logic i_ready,
  input logic i_fault,
  input logic i_uhit,
  input logic d_gnt,
  input logic i_gnt,
  input logic sw_we
);
  a_r3_d_local_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && d_uhit) |-> (d_ready && !d_fault));
  a_r3_i_local_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && i_uhit) |-> (i_ready && !i_fault));
  a_r4_d_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ready) |=> (d_ready || !d_req));
  a_r4_i_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && !i_ready && !d_req) |=> (i_ready || !i_req));
  a_r5_d_fault_ready: assert property (@(posedge clk) disable iff (!rst_n)
    d_fault |-> d_ready);
  a_r5_i_fault_ready: assert property (@(posedge clk) disable iff (!rst_n)
    i_fault |-> i_ready);
  a_r8_one_search: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({d_gnt, i_gnt}));
  a_r8_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ready && i_req && !i_ready) |=> !i_ready);
  a_r9_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (!d_uhit && !i_uhit));
endmodule

bind xlat_top xlat_checker u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .d_req(d_req), .d_ready(d_ready), .d_fault(d_fault), .d_uhit(d_uhit),
  .i_req(i_req), .i_ready(i_ready), .i_fault(i_fault), .i_uhit(i_uhit),
  .d_gnt(d_gnt), .i_gnt(i_gnt), .sw_we(sw_we)
);

// File: tb/xlat_top_test.sv
`timescale 1ns/1ps
module xlat_top_test;
  import xlat_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        i_req, d_req, i_ready, d_ready, i_fault, d_fault;
  logic [31:0] i_va, d_va, i_pa, d_pa;
  logic        sw_we, sw_valid;
  logic [4:0]  sw_idx;
  logic [1:0]  sw_psz;
  logic [21:0] sw_vpn, sw_ppn;

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  logic      mv [32];
  xlat_ent_t mm [32];
  logic      dv [8];
  xlat_ent_t dm [8];
  logic      iv [4];
  xlat_ent_t im [4];
  int dptr = 0;
  int iptr = 0;

  always #4 clk = ~clk;

  xlat_top uut (
    .clk(clk), .rst_n(rst_n),
    .i_req(i_req), .i_va(i_va), .i_ready(i_ready), .i_pa(i_pa), .i_fault(i_fault),
    .d_req(d_req), .d_va(d_va), .d_ready(d_ready), .d_pa(d_pa), .d_fault(d_fault),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_valid(sw_valid), .sw_psz(sw_psz),
    .sw_vpn(sw_vpn), .sw_ppn(sw_ppn)
  );

  function automatic int ofs_of(input logic [1:0] c);
    case (c)
      2'd0: return 10;
      2'd1: return 12;
      2'd2: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic logic m_match(input xlat_ent_t e, input logic [31:0] va);
    int o;
    o = ofs_of(e.psz);
    return (({e.vpn, 10'b0} >> o) == (va >> o));
  endfunction

  function automatic logic [31:0] exp_pa(input xlat_ent_t e, input logic [31:0] va);
    logic [31:0] lm;
    lm = (32'h1 << ofs_of(e.psz)) - 32'h1;
    return ({e.ppn, 10'b0} & ~lm) | (va & lm);
  endfunction

  function automatic int look_main(input logic [31:0] va);
    for (int k = 0; k < 32; k++) if (mv[k] && m_match(mm[k], va)) return k;
    return -1;
  endfunction

  function automatic int look_local(input bit is_d, input logic [31:0] va);
    if (is_d) begin
      for (int k = 0; k < 8; k++) if (dv[k] && m_match(dm[k], va)) return k;
    end else begin
      for (int k = 0; k < 4; k++) if (iv[k] && m_match(im[k], va)) return k;
    end
    return -1;
  endfunction

  function automatic xlat_ent_t mk(input logic [31:0] vb, input logic [31:0] pb, input logic [1:0] c);
    xlat_ent_t e;
    e.psz = c;
    e.vpn = vb[31:10];
    e.ppn = pb[31:10];
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic fill_model(input bit is_d, input xlat_ent_t e);
    if (is_d) begin dm[dptr] = e; dv[dptr] = 1'b1; dptr = (dptr + 1) % 8; end
    else      begin im[iptr] = e; iv[iptr] = 1'b1; iptr = (iptr + 1) % 4; end
  endtask

  task automatic sw_write(input int idx, input xlat_ent_t e, input logic vbit);
    @(negedge clk);
    d_req = 1'b0; i_req = 1'b0;
    sw_we = 1'b1; sw_idx = 5'(idx); sw_valid = vbit;
    sw_psz = e.psz; sw_vpn = e.vpn; sw_ppn = e.ppn;
    @(negedge clk);
    sw_we = 1'b0;
    mm[idx] = e; mv[idx] = vbit;
    for (int k = 0; k < 8; k++) dv[k] = 1'b0;
    for (int k = 0; k < 4; k++) iv[k] = 1'b0;
  endtask

  task automatic access(input bit is_d, input logic [31:0] va, input string tag);
    int u, m;
    logic rdy, flt;
    logic [31:0] pa;
    @(negedge clk);
    d_req = is_d; i_req = !is_d;
    if (is_d) d_va = va; else i_va = va;
    #1;
    u   = look_local(is_d, va);
    rdy = is_d ? d_ready : i_ready;
    flt = is_d ? d_fault : i_fault;
    pa  = is_d ? d_pa : i_pa;
    if (u >= 0) begin
      check(rdy && !flt, {tag, " local hit status"}, {30'b0, rdy, flt}, 32'h2);
      check(pa == exp_pa(is_d ? dm[u] : im[u], va), {tag, " local hit address"},
            pa, exp_pa(is_d ? dm[u] : im[u], va));
    end else begin
      check(!rdy && !flt, {tag, " stall status"}, {30'b0, rdy, flt}, 32'h0);
      @(negedge clk);
      #1;
      m   = look_main(va);
      rdy = is_d ? d_ready : i_ready;
      flt = is_d ? d_fault : i_fault;
      pa  = is_d ? d_pa : i_pa;
      if (m >= 0) begin
        check(rdy && !flt, {tag, " shared hit status"}, {30'b0, rdy, flt}, 32'h2);
        check(pa == exp_pa(mm[m], va), {tag, " shared hit address"}, pa, exp_pa(mm[m], va));
        fill_model(is_d, mm[m]);
      end else begin
        check(rdy && flt, {tag, " fault status"}, {30'b0, rdy, flt}, 32'h3);
      end
    end
  endtask

  task automatic finish_up;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %h expected %h", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    xlat_ent_t e;
    logic [31:0] va, lm;
    int j;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 32; k++) begin mv[k] = 1'b0; mm[k] = '0; end
    for (int k = 0; k < 8; k++) begin dv[k] = 1'b0; dm[k] = '0; end
    for (int k = 0; k < 4; k++) begin iv[k] = 1'b0; im[k] = '0; end
    rst_n = 1'b0; i_req = 0; d_req = 0; i_va = 0; d_va = 0;
    sw_we = 0; sw_idx = 0; sw_valid = 0; sw_psz = 0; sw_vpn = 0; sw_ppn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!d_ready && !i_ready, "R1 idle ready low", {30'b0, d_ready, i_ready}, 32'h0);
    access(1'b1, 32'h0000_0000, "R1 data after reset");
    access(1'b0, 32'h0000_1234, "R1 instr after reset");

    // R2: one entry per size code, ppn low bits set where they must be masked
    sw_write(0, mk(32'h1000_0000, 32'h8000_0000, 2'd0), 1'b1);
    sw_write(1, mk(32'h2000_0000, 32'h8010_0000, 2'd1), 1'b1);
    sw_write(2, mk(32'h3000_0000, 32'h8200_0000, 2'd2), 1'b1);
    e = mk(32'h4000_0000, 32'h9000_0000, 2'd3); e.ppn[9:0] = 10'h3FF;
    sw_write(3, e, 1'b1);
    for (int k = 0; k < 4; k++)
      sw_write(4 + k, mk(32'h5000_0000 + 32'(k) * 32'h400, 32'hA000_0000 + 32'(k) * 32'h400, 2'd0), 1'b1);
    access(1'b1, 32'h1000_03FC, "R2 1KB page");
    access(1'b1, 32'h1000_0400, "R2 1KB next page");
    access(1'b1, 32'h2000_0ABC, "R2 4KB page");
    access(1'b1, 32'h2000_1000, "R2 4KB next page");
    access(1'b1, 32'h3000_FFFF, "R2 64KB page");
    access(1'b1, 32'h4001_2345, "R2 1MB page");
    access(1'b1, 32'h4008_0001, "R2 1MB page again");
    access(1'b1, 32'h1000_0000, "R3 R6 local reuse");
    access(1'b1, 32'h7777_0000, "R5 unmapped");
    access(1'b1, 32'h7777_0000, "R5 unmapped repeat");

    // R7: five distinct pages through the 4-entry instruction buffer
    for (int k = 0; k < 4; k++) access(1'b0, 32'h5000_0000 + 32'(k) * 32'h400 + 32'h10, "R7 fill");
    access(1'b0, 32'h1000_0020, "R7 fifth page");
    access(1'b0, 32'h5000_0400, "R7 survivor");
    access(1'b0, 32'h5000_0000, "R7 replaced page");

    // R9: software write empties first-level buffers
    access(1'b1, 32'h2000_0004, "R9 before write");
    sw_write(20, mk(32'h6000_0000, 32'hB000_0000, 2'd1), 1'b1);
    access(1'b1, 32'h2000_0008, "R9 after write");
    access(1'b0, 32'h5000_0400, "R9 instr after write");

    // R8: both sides miss in the same cycle
    sw_write(21, mk(32'h6100_0000, 32'hB100_0000, 2'd0), 1'b1);
    @(negedge clk);
    d_req = 1; i_req = 1; d_va = 32'h2000_0010; i_va = 32'h3000_0020;
    #1;
    check(!d_ready && !i_ready, "R8 both stall", {30'b0, d_ready, i_ready}, 32'h0);
    @(negedge clk); #1;
    check(d_ready && !i_ready, "R8 data served first", {30'b0, d_ready, i_ready}, 32'h2);
    check(d_pa == exp_pa(mm[1], d_va), "R8 data address", d_pa, exp_pa(mm[1], d_va));
    fill_model(1'b1, mm[1]);
    @(negedge clk); #1;
    check(i_ready && !i_fault, "R8 instr served second", {30'b0, i_ready, i_fault}, 32'h2);
    check(i_pa == exp_pa(mm[2], i_va), "R8 instr address", i_pa, exp_pa(mm[2], i_va));
    fill_model(1'b0, mm[2]);

    // random phase
    for (int k = 0; k < 32; k++) begin
      e.psz = 2'($urandom);
      e.vpn = {5'(k), 17'($urandom)};
      e.ppn = 22'($urandom);
      sw_write(k, e, ($urandom % 8) != 0);
    end
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 50 == 0) begin
        j = $urandom % 32;
        e.psz = 2'($urandom);
        e.vpn = {5'(j), 17'($urandom)};
        e.ppn = 22'($urandom);
        sw_write(j, e, 1'b1);
      end
      j  = $urandom % 12;
      va = {mm[j].vpn, 10'($urandom)};
      lm = (32'h1 << ofs_of(mm[j].psz)) - 32'h1;
      if ($urandom % 2 == 1) va = va ^ ($urandom & lm);
      if ($urandom % 16 == 0) va = va ^ 32'h0040_0000;
      access(($urandom % 2) == 1, va, "R2 R3 R4 R5 R6 random");
    end
    @(negedge clk);
    d_req = 0; i_req = 0;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule